// File: doc/BRIEF.md
# Three-wire serial EEPROM shifter

This block is the master side of a three-wire serial memory link: a serial clock, one shared bidirectional data line, and a chip select. Chip select stays outside the block and is driven by software through a general-purpose output. Each write to the control port starts one transfer of zero to eight bits. Outgoing bits are shifted MSB first out of the top of an 8-bit data register. Incoming bits are shifted into the bottom of that register, so a short read ends up right-justified.

The serial clock comes from the system clock through a divider. Each half period lasts `HALF_DIV` system cycles, and the clock rests low between transfers. After the final rising edge the master can release the data line. In that case an optional wait-for-ready mode keeps the block busy until the memory pulls the line high, which is how the memory reports that its internal write has finished. When busy drops, an interrupt pulse lasting one cycle is raised.

Top module: `tw_eeprom_shifter`

## Requirements
- R1: A control write accepted while idle, with count field `ctl_wdata[3:0]` from 1 to 8, raises `busy` on the next cycle and issues exactly that many `sck` pulses. Each low half and each high half lasts `HALF_DIV` cycles, so `busy` stays high for 2*count*`HALF_DIV` cycles, and `sck` is low whenever `busy` is low.
- R2: With direction bit `ctl_wdata[4]`=0 (write), the bit on `sd_o` while `sck` rises is data bit 7, then 6, and so on. The register shifts left with zero fill on every falling edge, so it ends as the original value shifted left by count.
- R3: With `ctl_wdata[4]`=1 (read), the data register is cleared at the start. `sd_i` is shifted into bit 0 at every rising `sck` edge, which leaves the received bits right-justified, first bit highest. `sd_oe` is low during the clocks.
- R4: From the cycle in which the last `sck` rise occurs, `sd_oe` equals the inverse of the float bit `ctl_wdata[5]`. The line floats when the bit is 1 and is driven when it is 0. During write clocks `sd_oe` is 1.
- R5: A count of 0 issues no clock and no interrupt, and leaves `busy` low, unless wait-for-ready is in effect. From the next cycle on, `sd_oe` equals the inverse of the float bit.
- R6: Count values 9 to 15 behave as 8.
- R7: With wait-for-ready bit `ctl_wdata[6]`=1 and float bit 1, `busy` stays high after the last falling `sck` edge, with `sck` low. It drops on the clock edge at which `sd_i` is sampled 1 after having been sampled 0 one cycle earlier.
- R8: When the float bit is 0, the wait-for-ready bit has no effect on timing.
- R9: Control and data writes made while `busy` is high are ignored. The transfer in progress keeps its count, direction and data.
- R10: `done_irq` is high for exactly one cycle: the first cycle in which `busy` is low after having been high. It is never high at any other time. A control write in that same cycle is accepted.
- R11: After reset, `busy`, `sck`, `sd_oe`, `done_irq` and `data_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe; starts a transfer |
| ctl_wdata | input | 7 | [3:0] bit count, [4] read, [5] float after last rise, [6] wait for ready |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Value for the data register |
| data_q | output | 8 | Data register contents |
| busy | output | 1 | Transfer or ready wait in progress |
| done_irq | output | 1 | One-cycle pulse when busy falls |
| sck | output | 1 | Serial clock, idles low |
| sd_o | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_i | input | 1 | Data line input value |

## Verification
Two events can fall in the same cycle: the completion interrupt and a new control write. The bench waits for the cycle in which `done_irq` is high and drives a fresh control write in that cycle. The finishing transfer must still produce exactly one interrupt pulse. The new command must be accepted and must run with the data the previous transfer left behind. Each transfer is scored on its pulse count, its busy length and its final register value.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam int TW_DW    = 8;
  localparam int TW_CW    = $clog2(TW_DW + 1);
  localparam int TW_CTL_W = TW_CW + 3;

  typedef struct packed {
    logic             wait_rdy;
    logic             float_sd;
    logic             rd;
    logic [TW_CW-1:0] cnt;
  } tw_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_WAIT
  } tw_state_e;

  // Clamp the requested bit count to the register width.
  function automatic logic [TW_CW-1:0] tw_clamp(input logic [TW_CW-1:0] c);
    if (c > TW_CW'(TW_DW)) return TW_CW'(TW_DW);
    return c;
  endfunction

  function automatic tw_ctl_t tw_decode(input logic [TW_CTL_W-1:0] w);
    tw_ctl_t d;
    d.cnt      = tw_clamp(w[TW_CW-1:0]);
    d.rd       = w[TW_CW];
    d.float_sd = w[TW_CW+1];
    d.wait_rdy = w[TW_CW+2];
    return d;
  endfunction

  // Receive step: new bit enters at the bottom.
  function automatic logic [TW_DW-1:0] tw_shift_in(input logic [TW_DW-1:0] q,
                                                   input logic b);
    return {q[TW_DW-2:0], b};
  endfunction

  // Transmit step: MSB leaves, zero fills at the bottom.
  function automatic logic [TW_DW-1:0] tw_shift_out(input logic [TW_DW-1:0] q);
    return {q[TW_DW-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/tw_halfclk.sv
module tw_halfclk #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_done
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign half_done = run && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run || half_done) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tw_ready_det.sv
module tw_ready_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_i,
  output logic sd_rise
);
  logic prev_q;

  // The line has a pull-up, so the previous value resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sd_i;
  end

  assign sd_rise = sd_i & ~prev_q;
endmodule

// File: rtl/tw_shreg.sv
module tw_shreg
  import tw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [TW_DW-1:0] load_val,
  input  logic             shl_in,
  input  logic             shl_out,
  input  logic             in_bit,
  output logic [TW_DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (clr)     q <= '0;
    else if (load)    q <= load_val;
    else if (shl_in)  q <= tw_shift_in(q, in_bit);
    else if (shl_out) q <= tw_shift_out(q);
  end
endmodule

// File: rtl/tw_eeprom_shifter.sv
module tw_eeprom_shifter
  import tw_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [TW_CTL_W-1:0] ctl_wdata,
  input  logic                data_wr,
  input  logic [TW_DW-1:0]    data_wdata,
  output logic [TW_DW-1:0]    data_q,
  output logic                busy,
  output logic                done_irq,
  output logic                sck,
  output logic                sd_o,
  output logic                sd_oe,
  input  logic                sd_i
);

  tw_state_e        state_q, state_d;
  tw_ctl_t          ctl_q, dec;
  logic [TW_CW-1:0] left_q;
  logic             sck_q, oe_q, busy_d1;
  logic             run, half_done, sd_rise;

  // Named internal events (also observed by the checker)
  logic accept_evt, start_xfer, start_wait;
  logic low_end, high_end, last_bit, wait_eff;
  logic sck_rise_evt, shift_evt, xfer_read, in_wait;
  logic sh_clr, sh_load, sh_in, sh_out;

  assign dec        = tw_decode(ctl_wdata);
  assign busy       = (state_q != ST_IDLE);
  assign accept_evt = ctl_wr && !busy;
  assign start_xfer = accept_evt && (dec.cnt != '0);
  assign start_wait = accept_evt && (dec.cnt == '0) && dec.wait_rdy && dec.float_sd;

  assign run      = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign low_end  = (state_q == ST_LOW)  && half_done;
  assign high_end = (state_q == ST_HIGH) && half_done;
  assign last_bit = (left_q == TW_CW'(1));
  assign wait_eff = ctl_q.wait_rdy && ctl_q.float_sd;

  assign sck_rise_evt = low_end;
  assign xfer_read    = ctl_q.rd;
  assign in_wait      = (state_q == ST_WAIT);

  assign sh_clr    = start_xfer && dec.rd;
  assign sh_load   = data_wr && !busy;
  assign sh_in     = low_end && ctl_q.rd;
  assign sh_out    = high_end && !ctl_q.rd;
  assign shift_evt = sh_in || sh_out;

  tw_halfclk #(.HALF_DIV(HALF_DIV)) u_halfclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .half_done (half_done)
  );

  tw_ready_det u_ready (
    .clk     (clk),
    .rst_n   (rst_n),
    .sd_i    (sd_i),
    .sd_rise (sd_rise)
  );

  tw_shreg u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sh_clr),
    .load     (sh_load),
    .load_val (data_wdata),
    .shl_in   (sh_in),
    .shl_out  (sh_out),
    .in_bit   (sd_i),
    .q        (data_q)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_xfer)      state_d = ST_LOW;
        else if (start_wait) state_d = ST_WAIT;
      end
      ST_LOW:  if (low_end) state_d = ST_HIGH;
      ST_HIGH: begin
        if (high_end) begin
          if (!last_bit)     state_d = ST_LOW;
          else if (wait_eff) state_d = ST_WAIT;
          else               state_d = ST_IDLE;
        end
      end
      ST_WAIT: if (sd_rise) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
      left_q  <= '0;
      sck_q   <= 1'b0;
      oe_q    <= 1'b0;
      busy_d1 <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_d1 <= busy;
      if (accept_evt) begin
        ctl_q  <= dec;
        left_q <= dec.cnt;
      end else if (high_end) begin
        left_q <= left_q - 1'b1;
      end
      if (low_end)       sck_q <= 1'b1;
      else if (high_end) sck_q <= 1'b0;
      // Output enable: released for reads and waits, driven for writes,
      // then set by the float bit from the last rising edge onward.
      if (start_xfer)               oe_q <= !dec.rd;
      else if (start_wait)          oe_q <= 1'b0;
      else if (accept_evt)          oe_q <= !dec.float_sd;
      else if (low_end && last_bit) oe_q <= !ctl_q.float_sd;
    end
  end

  assign sck      = sck_q;
  assign sd_oe    = oe_q;
  assign sd_o     = data_q[TW_DW-1];
  assign done_irq = busy_d1 && !busy;

endmodule

// File: rtl/tw_eeprom_shifter_chk.sv
module tw_eeprom_shifter_chk
  import tw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             data_wr,
  input logic [TW_DW-1:0] data_q,
  input logic             busy,
  input logic             done_irq,
  input logic             sck,
  input logic             sd_oe,
  input logic             accept_evt,
  input logic             sck_rise_evt,
  input logic             shift_evt,
  input logic             xfer_read,
  input logic             in_wait
);
  logic [TW_CW:0] pulses_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pulses_q <= '0;
    else if (accept_evt)   pulses_q <= '0;
    else if (sck_rise_evt) pulses_q <= pulses_q + 1'b1;
  end

  // R1
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  // R3
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_read && !in_wait && !sck) |-> !sd_oe);

  // R6
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q <= (TW_CW+1)'(TW_DW));

  // R7
  wait_clock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (busy && !sck));

  // R9
  busy_data_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_wr && !shift_evt) |=> $stable(data_q));

  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy);

  // R11
  idle_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !data_wr && !ctl_wr) |=> $stable(data_q));

endmodule

bind tw_eeprom_shifter tw_eeprom_shifter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_wr       (ctl_wr),
  .data_wr      (data_wr),
  .data_q       (data_q),
  .busy         (busy),
  .done_irq     (done_irq),
  .sck          (sck),
  .sd_oe        (sd_oe),
  .accept_evt   (accept_evt),
  .sck_rise_evt (sck_rise_evt),
  .shift_evt    (shift_evt),
  .xfer_read    (xfer_read),
  .in_wait      (in_wait)
);

// File: tb/tw_eeprom_shifter_bench.sv
`timescale 1ns/1ps
module tw_eeprom_shifter_bench;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [6:0] ctl_wdata;
  logic       data_wr;
  logic [7:0] data_wdata;
  logic [7:0] data_q;
  logic       busy, done_irq, sck, sd_o, sd_oe, sd_i;

  logic       slave_en;
  logic       sd_force;
  logic [7:0] slv_byte;
  int         rx_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign sd_i = slave_en ? ((rx_idx < 8) ? slv_byte[3'(7 - rx_idx)] : 1'b0) : sd_force;

  tw_eeprom_shifter #(.HALF_DIV(H)) u_tw_eeprom_shifter (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .data_q(data_q),
    .busy(busy), .done_irq(done_irq), .sck(sck), .sd_o(sd_o),
    .sd_oe(sd_oe), .sd_i(sd_i)
  );

  typedef struct {
    int    pulses;
    int    busy_cyc;
    int    data;
    int    bits;
    bit    chk_bits;
    bit    oe_after;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Monitor / scoreboard
  logic m_prev_sck = 1'b0, m_prev_busy = 1'b0, m_prev_sdo = 1'b0;
  int   m_pulses = 0, m_bits = 0, m_bcyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !m_prev_busy) begin
        m_pulses = 0; m_bits = 0; m_bcyc = 0; rx_idx = 0;
      end
      if (busy) m_bcyc++;
      if (sck && !m_prev_sck) begin
        m_pulses++;
        m_bits = ((m_bits << 1) | int'(m_prev_sdo)) & 255;
        rx_idx++;
        if (exp_q.size() > 0 && m_pulses == exp_q[0].pulses)
          check(sd_oe == exp_q[0].oe_after, "R4 oe at last rise", int'(sd_oe), int'(exp_q[0].oe_after));
      end
      if (!busy && m_prev_busy) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected transfer", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          check(m_pulses == cur.pulses, {cur.tag, " pulse count"}, m_pulses, cur.pulses);
          if (cur.busy_cyc >= 0)
            check(m_bcyc == cur.busy_cyc, {cur.tag, " R1 busy length"}, m_bcyc, cur.busy_cyc);
          check(int'(data_q) == cur.data, {cur.tag, " data register"}, int'(data_q), cur.data);
          if (cur.chk_bits)
            check(m_bits == cur.bits, {cur.tag, " R2 serial bits"}, m_bits, cur.bits);
          check(done_irq == 1'b1, {cur.tag, " R10 irq at fall"}, int'(done_irq), 1);
        end
      end else if (done_irq) begin
        check(1'b0, "R10 stray irq", 1, 0);
      end
      m_prev_sck  = sck;
      m_prev_busy = busy;
      m_prev_sdo  = sd_o;
    end
  end

  // Driver tasks
  task automatic wr_data(input logic [7:0] d);
    @(negedge clk); data_wr = 1'b1; data_wdata = d;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [6:0] c);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = c;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic exp_t make_exp(input bit rd, input bit fl, input int cnt_raw,
                                    input logic [7:0] d, input logic [7:0] s,
                                    input string tag);
    exp_t e;
    int n;
    n = (cnt_raw > 8) ? 8 : cnt_raw;
    e.pulses   = n;
    e.busy_cyc = 2 * n * H;
    e.data     = rd ? (int'(s) >> (8 - n)) : ((int'(d) << n) & 255);
    e.bits     = int'(d) >> (8 - n);
    e.chk_bits = !rd;
    e.oe_after = !fl;
    e.tag      = tag;
    return e;
  endfunction

  task automatic xfer(input bit wt, input bit fl, input bit rd, input int cnt_raw,
                      input logic [7:0] d, input logic [7:0] s, input string tag);
    slv_byte = s;
    slave_en = 1'b1;
    wr_data(d);
    exp_q.push_back(make_exp(rd, fl, cnt_raw, d, s, tag));
    wr_ctl({wt, fl, rd, 4'(cnt_raw)});
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; data_wr = 1'b0; data_wdata = '0;
    slave_en = 1'b0; sd_force = 1'b0; slv_byte = '0; rx_idx = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(busy == 0 && sck == 0 && sd_oe == 0 && done_irq == 0, "R11 reset outputs",
          {busy, sck, sd_oe, done_irq}, 0);
    check(data_q == 8'h00, "R11 reset data", int'(data_q), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && sck == 0, "R11 after release", {busy, sck}, 0);

    // R2 full byte write, line kept driven
    xfer(1'b0, 1'b0, 1'b0, 8, 8'hA5, 8'h00, "R2");
    // R4 short write with float
    xfer(1'b0, 1'b1, 1'b0, 3, 8'hC0, 8'h00, "R4");
    // R1 single-bit write
    xfer(1'b0, 1'b0, 1'b0, 1, 8'h80, 8'h00, "R1");
    // R3 reads: full byte floated, short one driven afterwards
    xfer(1'b0, 1'b1, 1'b1, 8, 8'hFF, 8'h3C, "R3");
    xfer(1'b0, 1'b0, 1'b1, 5, 8'hFF, 8'hB7, "R3");
    // R6 over-range count
    xfer(1'b0, 1'b0, 1'b0, 13, 8'h81, 8'h00, "R6");
    // R8 wait-for-ready without float: normal timing
    xfer(1'b1, 1'b0, 1'b0, 2, 8'h6E, 8'h00, "R8");

    // R5 zero count
    wr_ctl(7'b000_0000);
    check(busy == 0 && sd_oe == 1 && sck == 0, "R5 zero count driven", {busy, sd_oe, sck}, 3'b010);
    repeat (6) @(negedge clk);
    check(busy == 0 && done_irq == 0, "R5 no busy no irq", {busy, done_irq}, 0);
    wr_ctl(7'b010_0000);
    check(busy == 0 && sd_oe == 0, "R5 zero count floated", {busy, sd_oe}, 0);
    repeat (3) @(negedge clk);

    // R7 wait for ready
    slave_en = 1'b0; sd_force = 1'b0;
    wr_data(8'h5A);
    begin
      exp_t e;
      e = make_exp(1'b0, 1'b1, 8, 8'h5A, 8'h00, "R7");
      e.busy_cyc = -1;
      exp_q.push_back(e);
    end
    wr_ctl({1'b1, 1'b1, 1'b0, 4'd8});
    repeat (2 * 8 * H + 10) @(negedge clk);
    check(busy == 1 && sck == 0, "R7 busy held in wait", {busy, sck}, 2'b10);
    sd_force = 1'b1;
    @(negedge clk);
    check(busy == 0, "R7 busy falls after line rise", int'(busy), 0);
    repeat (3) @(negedge clk);
    sd_force = 1'b0;
    slave_en = 1'b1;
    repeat (2) @(negedge clk);

    // R9 writes while busy are ignored
    wr_data(8'h96);
    exp_q.push_back(make_exp(1'b0, 1'b0, 4, 8'h96, 8'h00, "R9"));
    wr_ctl({1'b0, 1'b0, 1'b0, 4'd4});
    repeat (6) @(negedge clk);
    wr_ctl({1'b0, 1'b0, 1'b1, 4'd2});
    wr_data(8'h00);
    wait_idle();
    check(data_q == 8'h60, "R9 data kept after ignored writes", int'(data_q), 8'h60);
    repeat (5) @(negedge clk);
    check(busy == 0 && sck == 0, "R9 no late start", {busy, sck}, 0);

    // R10 control write in the interrupt cycle
    wr_data(8'hA5);
    exp_q.push_back(make_exp(1'b0, 1'b0, 4, 8'hA5, 8'h00, "R1"));
    wr_ctl({1'b0, 1'b0, 1'b0, 4'd4});
    while (!done_irq) @(negedge clk);
    exp_q.push_back(make_exp(1'b0, 1'b0, 4, 8'h50, 8'h00, "R10"));
    ctl_wr = 1'b1; ctl_wdata = {1'b0, 1'b0, 1'b0, 4'd4};
    @(negedge clk); ctl_wr = 1'b0;
    check(busy == 1 && done_irq == 0, "R10 accepted in irq cycle", {busy, done_irq}, 2'b10);
    wait_idle();

    check(exp_q.size() == 0, "R1 all transfers seen", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule